// File: doc/BRIEF.md
# Synchronous SPI Port with Select Gating and Collision Detect

This block is a full-duplex SPI port that can act either as the bus master or as a selected slave. Software talks to it through four small registers on a simple write/read bus. One data location feeds the transmit shifter on a write and returns the last received character on a read. A control register picks the mode, the clock polarity and phase, and the interrupt enable. A status register reports transfer-in-progress, end-of-transfer and collision, and a length register sets the character size anywhere from one to eight bits. Characters travel most significant bit first.

In master mode the port makes its own serial clock, one half-period per pulse of an external rate-enable input. During that time it watches the select pin. If another device pulls the select line low, the port records a collision, stops driving the clock and data lines, and drops back to slave mode. In slave mode the port moves data only while the select input is low. Clock activity meant for other slaves on a shared bus leaves both the loaded transmit character and the bit count untouched. All pins are sampled on the system clock.

Top module: `spi_port`

## Requirements
- R1: In master mode (CTRL bit0 enable = 1, bit1 master = 1), a character is sent on mosi_o and received from miso_i, most significant bit first. This holds in all four clock modes: CTRL bit2 sets the idle level of sck_o, and CTRL bit3 selects sampling on the second edge of each bit instead of the first. After the transfer, a read of address 0 returns the received character right-aligned, with the unused upper bits at zero.
- R2: STAT bit0 (busy) reads 1 on the first status read after a write to address 0, in both modes and before any clock edge has occurred. It returns to 0 when the last bit of the character completes.
- R3: In slave mode (CTRL bit0 = 1, bit1 = 0), sck_i edges seen while ss_n_i is high shift nothing, count no bits and set no flag. The character loaded beforehand is later sent whole when the port is selected.
- R4: STAT bit1 is set at the end of every transfer, whatever the value of CTRL bit4 (interrupt enable). It stays set until software writes 1 to STAT bit1. The irq output is high only while CTRL bit4 = 1 and STAT bit1 or STAT bit2 is set.
- R5: The length register (address 3, bits [2:0]) holds the character length minus one, so lengths of 1 to 8 bits are possible. One-bit characters transfer correctly in both master and slave mode.
- R6: When ss_n_i is low while the port is an enabled master, STAT bit2 (collision) is set and CTRL bit1 is cleared. The transfer in progress is abandoned with busy at 0, sck_oe and mosi_oe go low, and irq rises if CTRL bit4 = 1. Writing 1 to STAT bit2 clears the flag.
- R7: In slave mode with ss_n_i low, the loaded character is driven on miso_o most significant bit first, and the character on mosi_i is received. Received data reads back at address 0, and STAT bit1 is set at the end of the transfer.
- R8: After reset, CTRL reads 0, STAT reads 0, the length register reads 7, irq is 0, and all three output enables are 0.
- R9: sck_oe and mosi_oe are high exactly when the port is an enabled master. miso_oe is high exactly when the port is an enabled slave and ss_n_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Rate enable; each pulse is one master half-period |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 data, 1 control, 2 status, 3 length |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data of the selected register |
| sck_i | input | 1 | Serial clock from the bus (slave mode) |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Drive enable for sck_o |
| mosi_o | output | 1 | Master serial data out |
| mosi_oe | output | 1 | Drive enable for mosi_o |
| mosi_i | input | 1 | Serial data in when slave |
| miso_i | input | 1 | Serial data in when master |
| miso_o | output | 1 | Slave serial data out |
| miso_oe | output | 1 | Drive enable for miso_o |
| ss_n_i | input | 1 | Active-low select pin, also watched for collisions |
| irq | output | 1 | Registered interrupt request |

## Verification
The checker assumes a few things about the pins, because they are sampled directly on the system clock. Each sck_i level lasts at least two system clocks. mosi_i is stable across the clock where sck_i changes. ss_n_i never moves in the same cycle as an sck_i edge. Software does not write the data register during a transfer. The stimulus holds every serial level for three clocks, and changes data and select only half a bit away from the sampling edge. The external device the stimulus models answers the master's clock from the registered sck_o, so its data is settled well before the port samples it.

// File: rtl/spi_pkg.sv
package spi_pkg;
  typedef struct packed {
    logic irq_en;   // bit4
    logic cpha;     // bit3
    logic cpol;     // bit2
    logic master;   // bit1
    logic enable;   // bit0
  } spi_ctrl_t;

  localparam int CTRL_W = $bits(spi_ctrl_t);

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_LEN  = 2'd3;
endpackage

// File: rtl/spi_regs.sv
module spi_regs
  import spi_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [CTRL_W-1:0] w_ctl,
  input  logic [LW-1:0]     w_len,
  input  logic [1:0]        w_clr,
  input  logic              done,
  input  logic              busy,
  input  logic              ss_n,
  input  logic [DW-1:0]     rx_data,
  output spi_ctrl_t         ctrl,
  output logic [LW-1:0]     len_m1,
  output logic              collide,
  output logic              irq_flag,
  output logic              col_flag,
  output logic [DW-1:0]     rdata,
  output logic              irq
);
  logic wr_ctl, wr_len, wr_stat;

  assign wr_ctl  = wr_en && (addr == A_CTRL);
  assign wr_len  = wr_en && (addr == A_LEN);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign collide = ctrl.enable && ctrl.master && !ss_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      len_m1   <= '1;
      irq_flag <= 1'b0;
      col_flag <= 1'b0;
      rdata    <= '0;
      irq      <= 1'b0;
    end else begin
      if (wr_ctl) ctrl <= spi_ctrl_t'(w_ctl);
      if (collide) ctrl.master <= 1'b0;
      if (wr_len) len_m1 <= w_len;

      if (done) irq_flag <= 1'b1;
      else if (wr_stat && w_clr[0]) irq_flag <= 1'b0;

      if (collide) col_flag <= 1'b1;
      else if (wr_stat && w_clr[1]) col_flag <= 1'b0;

      irq <= ctrl.irq_en && (irq_flag || col_flag);

      case (addr)
        A_DATA:  rdata <= rx_data;
        A_CTRL:  rdata <= DW'(ctrl);
        A_STAT:  rdata <= DW'({col_flag, irq_flag, busy});
        default: rdata <= DW'(len_m1);
      endcase
    end
  end
endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen (
  input  logic clk,
  input  logic rst,
  input  logic mmode,
  input  logic smode,
  input  logic cpol,
  input  logic tick,
  input  logic busy,
  input  logic abort,
  input  logic sck_i,
  input  logic ss_n,
  output logic lead,
  output logic trail,
  output logic sck_o
);
  logic half, sck_q;
  logic m_run, s_sel;

  assign m_run = mmode && !abort && busy && tick;
  assign s_sel = smode && !ss_n;

  assign lead  = (m_run && !half) ||
                 (s_sel && (sck_i != cpol) && (sck_q == cpol));
  assign trail = (m_run && half) ||
                 (s_sel && (sck_i == cpol) && (sck_q != cpol));

  always_ff @(posedge clk) begin
    if (rst) begin
      half  <= 1'b0;
      sck_q <= 1'b0;
      sck_o <= 1'b0;
    end else begin
      sck_q <= sck_i;
      if (!mmode || abort || !busy) begin
        half  <= 1'b0;
        sck_o <= cpol;
      end else if (tick) begin
        half  <= !half;
        sck_o <= half ? cpol : !cpol;
      end
    end
  end
endmodule

// File: rtl/spi_shift.sv
module spi_shift #(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpha,
  input  logic [LW-1:0] len_m1,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          lead,
  input  logic          trail,
  input  logic          sin,
  input  logic          cnt_clr,
  input  logic          abort,
  output logic          sout,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_data
);
  logic [DW-1:0] sh, nxt, mask;
  logic [LW-1:0] cnt;
  logic          rbit;

  assign nxt  = {sh[DW-2:0], (cpha ? sin : rbit)};
  assign done = trail && (cnt == len_m1) && !load && !abort && !cnt_clr;

  always_comb begin
    for (int i = 0; i < DW; i++) mask[i] = (LW'(i) <= len_m1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      cnt     <= '0;
      rbit    <= 1'b0;
      sout    <= 1'b0;
      busy    <= 1'b0;
      rx_data <= '0;
    end else if (load) begin
      sh   <= load_data;
      cnt  <= '0;
      busy <= 1'b1;
      sout <= load_data[len_m1];
    end else if (abort) begin
      cnt  <= '0;
      busy <= 1'b0;
    end else if (cnt_clr) begin
      cnt <= '0;
    end else begin
      if (lead) begin
        if (!cpha) rbit <= sin;
        else       sout <= sh[len_m1];
      end
      if (trail) begin
        sh <= nxt;
        if (!cpha) sout <= nxt[len_m1];
        if (done) begin
          cnt     <= '0;
          busy    <= 1'b0;
          rx_data <= nxt & mask;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              ss_n_i,
  output logic              irq
);
  localparam int LW = $clog2(DATA_W);

  spi_ctrl_t         ctrl;
  logic [LW-1:0]     len_m1;
  logic [DATA_W-1:0] rx_data;
  logic busy, done, collide, lead, trail, sout;
  logic irq_flag, col_flag, mmode, smode, sin, data_wr;

  assign mmode   = ctrl.enable && ctrl.master;
  assign smode   = ctrl.enable && !ctrl.master;
  assign data_wr = wr_en && (addr == A_DATA);
  assign sin     = ctrl.master ? miso_i : mosi_i;

  assign sck_oe  = mmode;
  assign mosi_oe = mmode;
  assign miso_oe = smode && !ss_n_i;
  assign mosi_o  = sout;
  assign miso_o  = sout;

  spi_regs #(.DW(DATA_W), .LW(LW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .w_ctl(wdata[CTRL_W-1:0]), .w_len(wdata[LW-1:0]), .w_clr(wdata[2:1]),
    .done(done), .busy(busy), .ss_n(ss_n_i), .rx_data(rx_data),
    .ctrl(ctrl), .len_m1(len_m1), .collide(collide),
    .irq_flag(irq_flag), .col_flag(col_flag), .rdata(rdata), .irq(irq)
  );

  spi_sck_gen u_sck (
    .clk(clk), .rst(rst), .mmode(mmode), .smode(smode), .cpol(ctrl.cpol),
    .tick(tick), .busy(busy), .abort(collide), .sck_i(sck_i), .ss_n(ss_n_i),
    .lead(lead), .trail(trail), .sck_o(sck_o)
  );

  spi_shift #(.DW(DATA_W), .LW(LW)) u_shift (
    .clk(clk), .rst(rst), .cpha(ctrl.cpha), .len_m1(len_m1),
    .load(data_wr), .load_data(wdata), .lead(lead), .trail(trail),
    .sin(sin), .cnt_clr(smode && ss_n_i), .abort(collide),
    .sout(sout), .busy(busy), .done(done), .rx_data(rx_data)
  );
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic       clr_irq,
  input logic       en,
  input logic       mst,
  input logic       ss_n,
  input logic       busy,
  input logic       done,
  input logic       irq_flag,
  input logic       col_flag,
  input logic       sck_oe,
  input logic       mosi_oe
);
  AST_BUSY_AFTER_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd0) |=> busy); // R2

  AST_DESEL_NO_DONE: assert property (@(posedge clk) disable iff (rst)
    (en && !mst && ss_n) |-> !done); // R3

  AST_DONE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    done |=> irq_flag); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (irq_flag && !(wr_en && addr == 2'd2 && clr_irq)) |=> irq_flag); // R4

  AST_COLLIDE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (en && mst && !ss_n) |=> (col_flag && !sck_oe && !mosi_oe && !busy)); // R6
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .clr_irq(wdata[1]),
  .en(ctrl.enable), .mst(ctrl.master), .ss_n(ss_n_i), .busy(busy),
  .done(done), .irq_flag(irq_flag), .col_flag(col_flag),
  .sck_oe(sck_oe), .mosi_oe(mosi_oe)
);

// File: tb/tb_spi_port.sv
module tb_spi_port;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic sck_i = 1'b0, mosi_i = 1'b0, miso_i = 1'b0, ss_n_i = 1'b1;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, irq;

  int nchk = 0, nerr = 0, tcnt = 0;
  bit tick_en = 0;
  logic [4:0] mctl = 5'd0;   // bench mirror of the control register

  // bench-side slave model for master transfers
  bit bs_on = 0, bcpol = 0, bcpha = 0;
  int blen = 8, oi = 0;
  logic [7:0] bs_tx = 8'h00, bs_rx = 8'h00;
  logic prev_sck = 1'b0;

  always #10 clk = ~clk;

  spi_port #(.DATA_W(8)) dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sck_i(sck_i), .sck_o(sck_o),
    .sck_oe(sck_oe), .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .ss_n_i(ss_n_i),
    .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    tcnt++;
    tick = tick_en && (tcnt % 4 == 0);
  end

  always @(negedge clk) begin
    if (bs_on && sck_o !== prev_sck) begin
      if ((sck_o != bcpol) ^ bcpha) bs_rx = {bs_rx[6:0], mosi_o};
      else begin
        if (oi < blen) miso_i = bs_tx[blen-1-oi];
        oi++;
      end
    end
    prev_sck = sck_o;
  end

  // per-clock comparison of drive enables against the bench mirror
  always begin
    @(posedge clk);
    #5;
    if (!rst) begin
      chk("R9 sck_oe", sck_oe, mctl[0] & mctl[1]);
      chk("R9 mosi_oe", mosi_oe, mctl[0] & mctl[1]);
      chk("R9 miso_oe", miso_oe, mctl[0] & ~mctl[1] & ~ss_n_i);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    if (a == 2'd1) mctl = d[4:0];
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic m_xfer(input bit cpol, input bit cpha, input int len,
                        input logic [7:0] tx, input logic [7:0] slv);
    logic [7:0] d, m;
    m = 8'((1 << len) - 1);
    wr(2'd1, {4'b0000, cpha, cpol, 1'b1, 1'b1});
    wr(2'd3, 8'(len - 1));
    repeat (3) @(negedge clk);
    blen = len; bs_tx = slv; bcpol = cpol; bcpha = cpha; bs_rx = 8'h00;
    oi = cpha ? 0 : 1;
    miso_i = cpha ? 1'b0 : slv[len-1];
    bs_on = 1;
    wr(2'd0, tx);
    rd(2'd2, d); chk("R2 master busy right after write", d, 8'h01);
    tick_en = 1; repeat (8 * len + 24) @(negedge clk); tick_en = 0;
    rd(2'd2, d); chk("R2 R4 master status after transfer", d, 8'h02);
    rd(2'd0, d); chk("R1 R5 master received char", d, slv & m);
    chk("R1 R5 char seen on mosi", bs_rx & m, tx & m);
    chk("R4 irq low while disabled", irq, 0);
    wr(2'd2, 8'h02);
    rd(2'd2, d); chk("R4 flag cleared by write one", d, 8'h00);
    bs_on = 0;
  endtask

  task automatic s_xfer(input bit cpol, input bit cpha, input int len, input bit do_load,
                        input logic [7:0] ld, input logic [7:0] mtx);
    logic [7:0] d, m, mrx;
    m = 8'((1 << len) - 1); mrx = 8'h00;
    @(negedge clk); sck_i = cpol; ss_n_i = 1'b1;
    wr(2'd1, {4'b0000, cpha, cpol, 1'b0, 1'b1});
    wr(2'd3, 8'(len - 1));
    if (do_load) begin
      wr(2'd0, ld);
      rd(2'd2, d); chk("R2 slave busy right after write", d, 8'h01);
    end
    @(negedge clk); ss_n_i = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      if (!cpha) begin
        mosi_i = mtx[i]; repeat (3) @(negedge clk);
        sck_i = ~cpol;   repeat (3) @(negedge clk);
        mrx = {mrx[6:0], miso_o};
        sck_i = cpol;    repeat (3) @(negedge clk);
      end else begin
        sck_i = ~cpol; mosi_i = mtx[i]; repeat (3) @(negedge clk);
        mrx = {mrx[6:0], miso_o};
        sck_i = cpol;  repeat (3) @(negedge clk);
      end
    end
    ss_n_i = 1'b1; repeat (2) @(negedge clk);
    rd(2'd2, d); chk("R4 R7 slave status after transfer", d, 8'h02);
    rd(2'd0, d); chk("R7 R5 slave received char", d, mtx & m);
    chk("R7 R3 slave sent loaded char", mrx & m, ld & m);
    wr(2'd2, 8'h02);
  endtask

  initial begin
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    rd(2'd1, d); chk("R8 reset ctrl", d, 8'h00);
    rd(2'd2, d); chk("R8 reset status", d, 8'h00);
    rd(2'd3, d); chk("R8 reset length", d, 8'h07);
    chk("R8 reset irq", irq, 0);
    chk("R8 reset enables", {sck_oe, mosi_oe, miso_oe}, 0);

    m_xfer(0, 0, 8, 8'hA5, 8'h3C);
    m_xfer(0, 1, 8, 8'h96, 8'h5A);
    m_xfer(1, 0, 5, 8'h13, 8'h0E);
    m_xfer(1, 1, 8, 8'hC3, 8'h81);
    m_xfer(0, 0, 1, 8'h01, 8'h00);   // R5 single bit
    m_xfer(1, 1, 1, 8'h00, 8'h01);   // R5 single bit

    s_xfer(0, 0, 8, 1, 8'h6D, 8'hB2);
    s_xfer(1, 1, 1, 1, 8'h01, 8'h00); // R5 single bit slave
    s_xfer(1, 0, 6, 1, 8'h2A, 8'h15);

    // R3: deselected slave ignores a full byte of clocks
    @(negedge clk); sck_i = 1'b0; ss_n_i = 1'b1;
    wr(2'd1, 8'h09);                  // enable, slave, cpha=1
    wr(2'd3, 8'h07);
    wr(2'd0, 8'hC6);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); sck_i = 1'b1; mosi_i = 1'b1; repeat (3) @(negedge clk);
      sck_i = 1'b0; repeat (3) @(negedge clk);
    end
    rd(2'd2, d); chk("R3 no transfer while deselected", d, 8'h01);
    rd(2'd0, d); chk("R3 receive data untouched", d, 8'h15);
    s_xfer(0, 1, 8, 0, 8'hC6, 8'h39);

    // R4: interrupt output with enable set
    wr(2'd1, 8'h13);
    wr(2'd3, 8'h00);
    wr(2'd0, 8'h01);
    tick_en = 1; repeat (40) @(negedge clk); tick_en = 0;
    chk("R4 irq high after transfer", irq, 1);
    wr(2'd2, 8'h02); repeat (2) @(negedge clk);
    chk("R4 irq low after clear", irq, 0);

    // R6: collision while a master transfer is running
    wr(2'd3, 8'h07);
    wr(2'd0, 8'hF0);
    tick_en = 1; repeat (10) @(negedge clk);
    @(negedge clk); ss_n_i = 1'b0;
    @(posedge clk); #1; mctl[1] = 1'b0;
    tick_en = 0;
    repeat (4) @(negedge clk);
    chk("R6 irq on collision", irq, 1);
    chk("R6 clock and data released", {sck_oe, mosi_oe}, 0);
    rd(2'd1, d); chk("R6 master bit cleared", d, 8'h11);
    rd(2'd2, d); chk("R6 collision flag, busy dropped", d, 8'h04);
    @(negedge clk); ss_n_i = 1'b1;
    wr(2'd2, 8'h04);
    rd(2'd2, d); chk("R6 collision flag cleared", d, 8'h00);
    repeat (2) @(negedge clk);
    chk("R6 irq low after clear", irq, 0);

    repeat (5) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule